// File: doc/BRIEF.md
# Floating-Point Compare Condition Unit

This block compares two IEEE-754 operands, in either single or double precision, and records the relation as a 2-bit condition code. The code goes into one of four condition fields inside a status word that the block holds. A caller presents both operands together with a precision select, a signaling-compare flag, a two-bit field selector and the invalid-trap enable, and pulses a strobe. One cycle later the updated status word, the current and accrued invalid flags, a trap-type field and a trap request appear, and a done pulse marks them.

When either operand is a NaN the result is unordered. What happens next depends on the invalid-trap enable. If the trap is enabled, the block requests a trap and leaves every field as it was. If the trap is disabled, the block writes the unordered code into the selected field and records a sticky accrued invalid flag. The signaling flag is carried for the compare variant. Under this NaN rule both variants reach the same trap decision.

Top module: `fcmp_cond_unit`

## Requirements
- R1: The condition code is 2'b00 when the operands are equal, 2'b01 when A is less than B, 2'b10 when A is greater than B, and 2'b11 when they are unordered.
- R2: With BASE_POS = 0, field selector 0 writes status bits [1:0], selector 1 writes bits [23:22], selector 2 writes bits [25:24] and selector 3 writes bits [27:26]. All other status bits read as zero.
- R3: A compare changes only the selected 2-bit field. The other three fields keep their values.
- R4: With dbl_sel = 0, only bits [31:0] of each operand are compared as a single-precision value, and bits [63:32] are ignored. With dbl_sel = 1, all 64 bits form a double.
- R5: A NaN has an all-ones exponent and a nonzero fraction, whether quiet or signaling. Infinity is not a NaN. +0 and -0 compare equal.
- R6: If inv_trap_en = 1 and either operand is a NaN, in the signaling or the quiet variant, the block does the following: it asserts trap_req, sets inv_cur, sets trap_type to 3'd1, and leaves the status word unchanged.
- R7: A compare that does not trap sets trap_type to 3'd0 and clears inv_cur.
- R8: An unordered compare with inv_trap_en = 0 writes 2'b11 into the field and sets inv_acc. inv_acc stays set until reset.
- R9: Results appear on the first clock edge after cmp_valid, with done high for that one cycle. trap_req is high for that same single cycle only.
- R10: Reset clears the status word, inv_cur, inv_acc, trap_type, trap_req and done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmp_valid | input | 1 | Compare strobe |
| opnd_a | input | 64 | Operand A (single precision in bits [31:0]) |
| opnd_b | input | 64 | Operand B (single precision in bits [31:0]) |
| dbl_sel | input | 1 | 1 = double precision, 0 = single precision |
| signaling | input | 1 | Signaling-compare variant |
| fld_sel | input | 2 | Condition field to write |
| inv_trap_en | input | 1 | Invalid-operation trap enable |
| cc_word | output | BASE_POS+28 | Status word holding the four condition fields |
| inv_cur | output | 1 | Invalid flag of the latest compare |
| inv_acc | output | 1 | Sticky accrued invalid flag |
| trap_type | output | 3 | 0 = none, 1 = IEEE exception |
| trap_req | output | 1 | One-cycle trap request |
| done | output | 1 | Result valid pulse |

## Verification
The bench compares operands with opposite signs and with equal signs. With both operands negative, a design that left out the magnitude reversal would swap less and greater. It compares +0 against -0 in both precisions, where a plain bit compare would wrongly report a sign order. It also checks that infinity is not classed as a NaN. Single-precision vectors carry all-ones upper halves, so a design that read the full 64 bits would see NaNs and report unordered. Quiet and signaling NaNs are tested with the trap both enabled and disabled. A design that wrote the field during a trap, lost the accrued flag, or left a stale trap type on the next compare would show up as a status word or flag mismatch.

// File: rtl/fcmp_pkg.sv
package fcmp_pkg;
  typedef logic [1:0] cc_t;
  localparam cc_t CC_EQ  = 2'b00;
  localparam cc_t CC_LT  = 2'b01;
  localparam cc_t CC_GT  = 2'b10;
  localparam cc_t CC_UNO = 2'b11;

  localparam int TT_W = 3;
  localparam logic [TT_W-1:0] TT_NONE = 3'd0;
  localparam logic [TT_W-1:0] TT_IEEE = 3'd1;

  localparam int NFLD = 4;

  // bit offset of condition field i relative to the base
  function automatic int fld_off(input int i);
    case (i)
      1:       fld_off = 22;
      2:       fld_off = 24;
      3:       fld_off = 26;
      default: fld_off = 0;
    endcase
  endfunction

  function automatic logic is_nan(input logic [63:0] v, input logic dbl);
    if (dbl) is_nan = (&v[62:52]) && (|v[51:0]);
    else     is_nan = (&v[30:23]) && (|v[22:0]);
  endfunction

  // ordered relation of two non-NaN operands
  function automatic cc_t ordered_rel(input logic [63:0] a, input logic [63:0] b,
                                      input logic dbl);
    logic sa, sb, lt;
    logic [62:0] ma, mb;
    sa = dbl ? a[63] : a[31];
    sb = dbl ? b[63] : b[31];
    ma = dbl ? a[62:0] : {32'd0, a[30:0]};
    mb = dbl ? b[62:0] : {32'd0, b[30:0]};
    if (ma == '0 && mb == '0)      ordered_rel = CC_EQ;
    else if (sa != sb)             ordered_rel = sa ? CC_LT : CC_GT;
    else if (ma == mb)             ordered_rel = CC_EQ;
    else begin
      lt = (ma < mb) ^ sa;
      ordered_rel = lt ? CC_LT : CC_GT;
    end
  endfunction
endpackage

// File: rtl/fcmp_nan_detect.sv
module fcmp_nan_detect (
  input  logic [63:0] opnd,
  input  logic        dbl,
  output logic        nan
);
  import fcmp_pkg::*;
  always_comb nan = is_nan(opnd, dbl);
endmodule

// File: rtl/fcmp_relation.sv
module fcmp_relation (
  input  logic [63:0]     opnd_a,
  input  logic [63:0]     opnd_b,
  input  logic            dbl,
  input  logic            nan_any,
  output fcmp_pkg::cc_t   code
);
  import fcmp_pkg::*;
  always_comb begin
    if (nan_any) code = CC_UNO;
    else         code = ordered_rel(opnd_a, opnd_b, dbl);
  end
endmodule

// File: rtl/fcmp_cc_regs.sv
module fcmp_cc_regs #(
  parameter int BASE_POS = 0,
  localparam int WORD_W = BASE_POS + 28
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      upd_valid,
  input  logic [1:0]                upd_sel,
  input  fcmp_pkg::cc_t             upd_code,
  input  logic                      take_trap,
  output logic [WORD_W-1:0]         cc_word,
  output logic                      inv_cur,
  output logic                      inv_acc,
  output logic [fcmp_pkg::TT_W-1:0] trap_type,
  output logic                      trap_req,
  output logic                      done
);
  import fcmp_pkg::*;

  cc_t        fld_q [NFLD];
  logic [1:0] sel_q;

  for (genvar i = 0; i < NFLD; i++) begin : g_fld
    always_ff @(posedge clk) begin
      if (!rst_n)                                                  fld_q[i] <= CC_EQ;
      else if (upd_valid && !take_trap && upd_sel == 2'(i))        fld_q[i] <= upd_code;
    end

    // a_r3_other_fields: an unselected field keeps its value
    a_r3_other_fields: assert property (@(posedge clk) disable iff (!rst_n)
      (done && sel_q != 2'(i)) |-> $stable(fld_q[i]));
  end

  always_comb begin
    cc_word = '0;
    for (int i = 0; i < NFLD; i++)
      cc_word[BASE_POS + fld_off(i) +: 2] = fld_q[i];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      inv_cur   <= 1'b0;
      inv_acc   <= 1'b0;
      trap_type <= TT_NONE;
      trap_req  <= 1'b0;
      done      <= 1'b0;
      sel_q     <= '0;
    end else begin
      done     <= upd_valid;
      trap_req <= upd_valid && take_trap;
      if (upd_valid) begin
        sel_q     <= upd_sel;
        inv_cur   <= take_trap;
        trap_type <= take_trap ? TT_IEEE : TT_NONE;
        if (!take_trap && upd_code == CC_UNO) inv_acc <= 1'b1;
      end
    end
  end

  a_r6_trap_keeps_word: assert property (@(posedge clk) disable iff (!rst_n)
    trap_req |-> $stable(cc_word));
  a_r6_trap_type_set: assert property (@(posedge clk) disable iff (!rst_n)
    trap_req |-> (trap_type == TT_IEEE && inv_cur));
  a_r9_done_after_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    upd_valid |=> done);
  a_r9_trap_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    trap_req |-> done);
  a_r8_acc_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    $past(inv_acc) |-> inv_acc);
endmodule

// File: rtl/fcmp_cond_unit.sv
module fcmp_cond_unit #(
  parameter int BASE_POS = 0,
  localparam int WORD_W = BASE_POS + 28
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmp_valid,
  input  logic [63:0]       opnd_a,
  input  logic [63:0]       opnd_b,
  input  logic              dbl_sel,
  input  logic              signaling,
  input  logic [1:0]        fld_sel,
  input  logic              inv_trap_en,
  output logic [WORD_W-1:0] cc_word,
  output logic              inv_cur,
  output logic              inv_acc,
  output logic [2:0]        trap_type,
  output logic              trap_req,
  output logic              done
);
  import fcmp_pkg::*;

  logic [63:0] opnd [2];
  logic [1:0]  nan_vec;
  logic        nan_any;
  logic        sig_trap;
  logic        uno_trap;
  logic        take_trap;
  cc_t         code;

  assign opnd[0] = opnd_a;
  assign opnd[1] = opnd_b;

  for (genvar k = 0; k < 2; k++) begin : g_nan
    fcmp_nan_detect u_nan (.opnd(opnd[k]), .dbl(dbl_sel), .nan(nan_vec[k]));
  end

  assign nan_any = |nan_vec;

  fcmp_relation u_rel (
    .opnd_a (opnd_a),
    .opnd_b (opnd_b),
    .dbl    (dbl_sel),
    .nan_any(nan_any),
    .code   (code)
  );

  // signaling variant traps on any NaN; both variants trap on unordered
  assign sig_trap  = signaling && nan_any && inv_trap_en;
  assign uno_trap  = (code == CC_UNO) && inv_trap_en;
  assign take_trap = sig_trap || uno_trap;

  fcmp_cc_regs #(.BASE_POS(BASE_POS)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .upd_valid(cmp_valid),
    .upd_sel  (fld_sel),
    .upd_code (code),
    .take_trap(take_trap),
    .cc_word  (cc_word),
    .inv_cur  (inv_cur),
    .inv_acc  (inv_acc),
    .trap_type(trap_type),
    .trap_req (trap_req),
    .done     (done)
  );

  // a_r5_nan_is_unordered: a NaN operand never yields an ordered code
  a_r5_nan_is_unordered: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_valid && nan_any) |-> (code == CC_UNO));
  a_r6_trap_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    trap_req |-> ($past(inv_trap_en) && $past(nan_any)));
endmodule

// File: tb/fcmp_cond_unit_tb_top.sv
module fcmp_cond_unit_tb_top;
  localparam int WORD_W = 28;
  localparam int NV = 13;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              cmp_valid = 1'b0;
  logic [63:0]       opnd_a = '0;
  logic [63:0]       opnd_b = '0;
  logic              dbl_sel = 1'b0;
  logic              signaling = 1'b0;
  logic [1:0]        fld_sel = '0;
  logic              inv_trap_en = 1'b0;
  logic [WORD_W-1:0] cc_word;
  logic              inv_cur, inv_acc, trap_req, done;
  logic [2:0]        trap_type;

  int checks = 0;
  int errors = 0;
  logic finished = 1'b0;

  always #10 clk = ~clk;

  fcmp_cond_unit dut_i (
    .clk(clk), .rst_n(rst_n), .cmp_valid(cmp_valid), .opnd_a(opnd_a), .opnd_b(opnd_b),
    .dbl_sel(dbl_sel), .signaling(signaling), .fld_sel(fld_sel), .inv_trap_en(inv_trap_en),
    .cc_word(cc_word), .inv_cur(inv_cur), .inv_acc(inv_acc), .trap_type(trap_type),
    .trap_req(trap_req), .done(done)
  );

  // {dbl, sig, trap_en, fld[1:0], a[63:0], b[63:0], code[1:0], trap}
  localparam logic [135:0] VEC [NV] = '{
    {1'b0,1'b0,1'b0,2'd0,64'hFFFFFFFF_3F800000,64'hFFFFFFFF_40000000,2'b01,1'b0},
    {1'b0,1'b0,1'b0,2'd1,64'hFFFFFFFF_40000000,64'hFFFFFFFF_3F800000,2'b10,1'b0},
    {1'b0,1'b0,1'b0,2'd2,64'h00000000_00000000,64'h00000000_80000000,2'b00,1'b0},
    {1'b0,1'b0,1'b0,2'd3,64'h00000000_C0000000,64'h00000000_BF800000,2'b01,1'b0},
    {1'b1,1'b0,1'b0,2'd0,64'h40000000_00000000,64'h3FF00000_00000000,2'b10,1'b0},
    {1'b1,1'b0,1'b0,2'd1,64'hC0080000_00000000,64'h3FF00000_00000000,2'b01,1'b0},
    {1'b0,1'b0,1'b0,2'd2,64'h00000000_7FC00000,64'h00000000_3F800000,2'b11,1'b0},
    {1'b1,1'b0,1'b1,2'd3,64'h3FF00000_00000000,64'h7FF80000_00000000,2'b11,1'b1},
    {1'b0,1'b1,1'b1,2'd0,64'h00000000_7F800001,64'h00000000_3F800000,2'b11,1'b1},
    {1'b0,1'b0,1'b0,2'd3,64'h00000000_7F800000,64'h00000000_40000000,2'b10,1'b0},
    {1'b1,1'b1,1'b0,2'd1,64'h3FF00000_00000000,64'h3FF00000_00000000,2'b00,1'b0},
    {1'b0,1'b1,1'b0,2'd0,64'h00000000_7FC00000,64'h00000000_7FC00000,2'b11,1'b0},
    {1'b1,1'b0,1'b0,2'd2,64'h80000000_00000000,64'h00000000_00000000,2'b00,1'b0}
  };

  logic [WORD_W-1:0] model_word = '0;
  logic              model_acc  = 1'b0;

  task automatic chk(input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic run_vec(input int idx);
    logic [135:0] v;
    logic         trap;
    logic [1:0]   code;
    int           pos;
    v    = VEC[idx];
    trap = v[0];
    code = v[2:1];
    @(negedge clk);
    dbl_sel = v[135]; signaling = v[134]; inv_trap_en = v[133]; fld_sel = v[132:131];
    opnd_a = v[130:67]; opnd_b = v[66:3]; cmp_valid = 1'b1;
    @(negedge clk);
    cmp_valid = 1'b0;
    if (!trap) begin
      pos = (v[132:131] == 2'd0) ? 0 : 20 + 2 * int'(v[132:131]);
      model_word[pos +: 2] = code;
      if (code == 2'b11) model_acc = 1'b1;
    end
    // R1 R2 R3 R4 R5: status word against the model
    chk(trap ? "R6" : "R1/R2/R3/R4/R5", $sformatf("word vec%0d", idx),
        64'(cc_word), 64'(model_word));
    chk("R9", $sformatf("done vec%0d", idx), 64'(done), 64'd1);
    chk("R9", $sformatf("trap_req vec%0d", idx), 64'(trap_req), 64'(trap));
    chk(trap ? "R6" : "R7", $sformatf("inv_cur vec%0d", idx), 64'(inv_cur), 64'(trap));
    chk(trap ? "R6" : "R7", $sformatf("trap_type vec%0d", idx), 64'(trap_type),
        trap ? 64'd1 : 64'd0);
    chk("R8", $sformatf("inv_acc vec%0d", idx), 64'(inv_acc), 64'(model_acc));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10: reset state
    chk("R10", "word after reset", 64'(cc_word), 64'd0);
    chk("R10", "flags after reset", 64'({inv_cur, inv_acc, trap_req, done}), 64'd0);
    chk("R10", "trap_type after reset", 64'(trap_type), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      run_vec(i);
      if (i == 8) begin
        // R9: trap request and done last one cycle
        @(negedge clk);
        chk("R9", "trap_req pulse width", 64'(trap_req), 64'd0);
        chk("R9", "done pulse width", 64'(done), 64'd0);
      end
    end

    // R8: accrued flag survives further ordered compares, R10: reset clears it
    chk("R8", "acc sticky", 64'(inv_acc), 64'd1);
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk("R10", "word after mid reset", 64'(cc_word), 64'd0);
    chk("R10", "acc after mid reset", 64'(inv_acc), 64'd0);
    rst_n = 1'b1;

    finished = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule